// File: doc/BRIEF.md
# Packed SIMD Saturating Subtractor

This block takes two packed operand vectors and, lane by lane, subtracts the second from the first. When a difference falls outside the range of the lane type, the block clamps it to the nearest representable value instead of letting it wrap. Each operation picks its own lane width (8, 16, 32 or 64 bits), its own signedness and its own vector width (64 or 128 bits).

Operations arrive on a valid/ready port. The port is always ready, so each accepted operation produces a registered result one cycle later. The result comes with a mask that shows which lanes were clamped. A sticky flag collects clamping events across operations and keeps them until a dedicated clear input drops it. A pipeline uses the block as the integer execution stage for vector saturating subtraction, and reads the sticky flag as a cumulative status bit.

Top module: `simd_sat_sub`

## Requirements
- R1: Each result lane holds the first-operand lane minus the second-operand lane, in the same lane position, whenever that difference fits in the lane type.
- R2: The size code sets the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, 2'b10 gives 32-bit lanes and 2'b11 gives 64-bit lanes. Lane i occupies bits [i*W +: W].
- R3: isUnsigned = 0 selects two's-complement lanes and isUnsigned = 1 selects unsigned lanes. All lanes of an operation use the same type.
- R4: In unsigned mode, a lane whose difference would be negative gives zero.
- R5: In signed mode, a lane that overflows gives the most negative value of the lane if the first operand is negative, and the most positive value otherwise.
- R6: With wideSel = 0 the vector is 64 bits wide. Result bits [127:64] are zero, and the upper lanes never set the saturation mask or the flag, whatever their contents. With wideSel = 1 all 128 bits are used.
- R7: opReady is always 1. An operation accepted at a clock edge shows its result, mask and resValid = 1 after the next edge. resValid is 0 in any cycle that follows an edge with no accepted operation.
- R8: satMask bit i is 1 exactly when lane i was clamped in the last operation. Bits at or above the active lane count are 0.
- R9: satFlag goes to 1 after any accepted operation that clamps at least one lane. It then stays 1 through operations that do not clamp.
- R10: clearFlag = 1 at an edge drops satFlag to 0. This wins over a clamping operation accepted at the same edge, although that operation's mask is still reported.
- R11: Reset (rstN low) gives resValid = 0, resData = 0, satMask = 0 and satFlag = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation offered |
| opReady | output | 1 | Operation can be taken (always 1) |
| opA | input | 128 | Minuend vector |
| opB | input | 128 | Subtrahend vector |
| sizeCode | input | 2 | Lane width code |
| isUnsigned | input | 1 | 1 = unsigned lanes, 0 = signed lanes |
| wideSel | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| clearFlag | input | 1 | Clears the sticky saturation flag |
| resValid | output | 1 | Registered result is new this cycle |
| resData | output | 128 | Clamped difference vector |
| satMask | output | 16 | Per-lane clamp indicators of the last operation |
| satFlag | output | 1 | Sticky cumulative saturation flag |

## Verification
The assertions assume that opValid, clearFlag and the operation fields are steady, known values at every clock edge after reset. They also assume the size code is one of the four legal encodings, which a 2-bit field always is. The bench changes every input only on the falling clock edge and holds the operation fields while opValid is high. It mixes clear pulses with and without a same-edge operation, so the priority property sees both cases.

// File: rtl/psub_pkg.sv
package psub_pkg;
  typedef enum logic [1:0] {
    LANE8  = 2'b00,
    LANE16 = 2'b01,
    LANE32 = 2'b10,
    LANE64 = 2'b11
  } laneSize_e;

  // Strobes from the control unit into the datapath
  typedef struct packed {
    logic loadRes;
    logic clrFlag;
  } dpCtrl_t;
endpackage

// File: rtl/psub_lane.sv
module psub_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         isUns,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};

  logic [W:0] diffX;
  logic       borrowOut;
  logic       signOvf;

  assign diffX     = {1'b0, a} - {1'b0, b};
  assign borrowOut = diffX[W];
  // operands of opposite sign whose result sign leaves the minuend sign
  assign signOvf   = (a[W-1] ^ b[W-1]) & (diffX[W-1] ^ a[W-1]);

  always_comb begin
    if (isUns) begin
      sat = borrowOut;
      res = borrowOut ? '0 : diffX[W-1:0];
    end else begin
      sat = signOvf;
      res = signOvf ? (a[W-1] ? S_MIN : S_MAX) : diffX[W-1:0];
    end
  end
endmodule

// File: rtl/psub_dp.sv
module psub_dp
  import psub_pkg::*;
#(
  parameter int VEC_W      = 128,
  parameter int MIN_LANE_W = 8,
  parameter int SIZE_CNT   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpCtrl_t                     ctrl,
  input  logic [VEC_W-1:0]            opA,
  input  logic [VEC_W-1:0]            opB,
  input  logic [1:0]                  sizeCode,
  input  logic                        isUnsigned,
  input  logic                        wideSel,
  output logic [VEC_W-1:0]            resData,
  output logic [VEC_W/MIN_LANE_W-1:0] satMask,
  output logic                        satFlag
);
  localparam int MAX_LANES = VEC_W / MIN_LANE_W;
  localparam int HALF_W    = VEC_W / 2;

  logic [SIZE_CNT-1:0][VEC_W-1:0]     sizeRes;
  logic [SIZE_CNT-1:0][MAX_LANES-1:0] sizeMask;
  logic [VEC_W-1:0]                   selRes;
  logic [VEC_W-1:0]                   resNext;
  logic [MAX_LANES-1:0]               maskNext;

  for (genvar s = 0; s < SIZE_CNT; s++) begin : g_size
    localparam int LW = MIN_LANE_W << s;
    localparam int NL = VEC_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic laneSat;
      psub_lane #(.W(LW)) u_lane (
        .a    (opA[l*LW +: LW]),
        .b    (opB[l*LW +: LW]),
        .isUns(isUnsigned),
        .res  (sizeRes[s][l*LW +: LW]),
        .sat  (laneSat)
      );
      // upper-half lanes report only in the 128-bit mode
      if (l < NL / 2) begin : g_low
        assign sizeMask[s][l] = laneSat;
      end else begin : g_high
        assign sizeMask[s][l] = laneSat & wideSel;
      end
    end
    for (genvar z = NL; z < MAX_LANES; z++) begin : g_pad
      assign sizeMask[s][z] = 1'b0;
    end
  end

  assign selRes   = sizeRes[sizeCode];
  assign maskNext = sizeMask[sizeCode];
  assign resNext  = wideSel ? selRes : {{HALF_W{1'b0}}, selRes[HALF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData <= '0;
      satMask <= '0;
    end else if (ctrl.loadRes) begin
      resData <= resNext;
      satMask <= maskNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                               satFlag <= 1'b0;
    else if (ctrl.clrFlag)                   satFlag <= 1'b0;
    else if (ctrl.loadRes && (|maskNext))    satFlag <= 1'b1;
  end

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrFlag |=> !satFlag);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !ctrl.clrFlag) |=> satFlag);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadRes && !ctrl.clrFlag && (|maskNext)) |=> satFlag);

  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadRes && !wideSel) |=> (resData[VEC_W-1:HALF_W] == '0));

  // R8
  mask_lane_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadRes && sizeCode == LANE64) |=> (satMask[MAX_LANES-1:2] == '0));
endmodule

// File: rtl/psub_ctrl.sv
module psub_ctrl
  import psub_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    opValid,
  input  logic    clearFlag,
  output logic    opReady,
  output logic    resValid,
  output dpCtrl_t ctrl
);
  logic accept;

  assign opReady      = 1'b1;
  assign accept       = opValid & opReady;
  assign ctrl.loadRes = accept;
  assign ctrl.clrFlag = clearFlag;

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= accept;
  end

  // R7
  result_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opReady) |=> resValid);

  // R7
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resValid);
endmodule

// File: rtl/simd_sat_sub.sv
module simd_sat_sub
  import psub_pkg::*;
#(
  parameter int VEC_W      = 128,
  parameter int MIN_LANE_W = 8,
  parameter int SIZE_CNT   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        opValid,
  output logic                        opReady,
  input  logic [VEC_W-1:0]            opA,
  input  logic [VEC_W-1:0]            opB,
  input  logic [1:0]                  sizeCode,
  input  logic                        isUnsigned,
  input  logic                        wideSel,
  input  logic                        clearFlag,
  output logic                        resValid,
  output logic [VEC_W-1:0]            resData,
  output logic [VEC_W/MIN_LANE_W-1:0] satMask,
  output logic                        satFlag
);
  dpCtrl_t ctrl;

  psub_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .clearFlag(clearFlag),
    .opReady  (opReady),
    .resValid (resValid),
    .ctrl     (ctrl)
  );

  psub_dp #(
    .VEC_W     (VEC_W),
    .MIN_LANE_W(MIN_LANE_W),
    .SIZE_CNT  (SIZE_CNT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .opA       (opA),
    .opB       (opB),
    .sizeCode  (sizeCode),
    .isUnsigned(isUnsigned),
    .wideSel   (wideSel),
    .resData   (resData),
    .satMask   (satMask),
    .satFlag   (satFlag)
  );
endmodule

// File: tb/tb_simd_sat_sub.sv
`timescale 1ns/1ps
module tb_simd_sat_sub;
  typedef struct packed {
    logic [1:0]   sz;
    logic         uns;
    logic         wide;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] exp;
    logic [15:0]  mask;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    // 0: R1 R2 byte lanes, signed, no clamp
    '{2'b00, 1'b0, 1'b1, {16{8'h05}}, {16{8'h03}}, {16{8'h02}}, 16'h0000},
    // 1: R5 signed byte lanes clamp to most negative
    '{2'b00, 1'b0, 1'b1, {16{8'h80}}, {16{8'h01}}, {16{8'h80}}, 16'hFFFF},
    // 2: R3 R4 unsigned byte lanes clamp to zero
    '{2'b00, 1'b1, 1'b1, {16{8'h01}}, {16{8'h02}}, 128'h0, 16'hFFFF},
    // 3: R5 signed halfword lanes clamp to most positive
    '{2'b01, 1'b0, 1'b1, {8{16'h7FFF}}, {8{16'hFFFF}}, {8{16'h7FFF}}, 16'h00FF},
    // 4: R4 R6 unsigned word lanes, narrow vector, mixed lanes
    '{2'b10, 1'b1, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 32'h10, 32'h5},
      {64'h0, 32'h20, 32'h3}, {64'h0, 32'h0, 32'h2}, 16'h0002},
    // 5: R5 R1 signed doubleword lanes, one clamps
    '{2'b11, 1'b0, 1'b1, {64'h8000_0000_0000_0000, 64'd10},
      {64'd1, 64'd20}, {64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFF6}, 16'h0002},
    // 6: R1 R3 unsigned doubleword lanes, no clamp
    '{2'b11, 1'b1, 1'b1, {64'd5, 64'hFFFF_FFFF_FFFF_FFFF},
      {64'd5, 64'd1}, {64'd0, 64'hFFFF_FFFF_FFFF_FFFE}, 16'h0000},
    // 7: R6 narrow vector, only upper lanes would clamp
    '{2'b00, 1'b0, 1'b0, {{8{8'h80}}, {8{8'h10}}}, {{8{8'h01}}, {8{8'h01}}},
      {64'h0, {8{8'h0F}}}, 16'h0000}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic         opReady;
  logic [127:0] opA = '0;
  logic [127:0] opB = '0;
  logic [1:0]   sizeCode = '0;
  logic         isUnsigned = 1'b0;
  logic         wideSel = 1'b0;
  logic         clearFlag = 1'b0;
  logic         resValid;
  logic [127:0] resData;
  logic [15:0]  satMask;
  logic         satFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  simd_sat_sub dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
    .opA(opA), .opB(opB), .sizeCode(sizeCode), .isUnsigned(isUnsigned),
    .wideSel(wideSel), .clearFlag(clearFlag), .resValid(resValid),
    .resData(resData), .satMask(satMask), .satFlag(satFlag)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doOp(input vec_t v, input logic clr);
    @(negedge clk);
    opA = v.a; opB = v.b; sizeCode = v.sz; isUnsigned = v.uns; wideSel = v.wide;
    opValid = 1'b1; clearFlag = clr;
    @(negedge clk);
    opValid = 1'b0; clearFlag = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 resValid", {127'b0, resValid}, 128'h0);
    check("R11 resData", resData, 128'h0);
    check("R11 satMask", {112'b0, satMask}, 128'h0);
    check("R11 satFlag", {127'b0, satFlag}, 128'h0);
    check("R7 opReady", {127'b0, opReady}, 128'h1);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      doOp(VECS[i], 1'b0);
      check($sformatf("R7 resValid vec %0d", i), {127'b0, resValid}, 128'h1);
      check($sformatf("R1 R2 resData vec %0d", i), resData, VECS[i].exp);
      check($sformatf("R8 satMask vec %0d", i), {112'b0, satMask}, {112'b0, VECS[i].mask});
    end
    // R9 flag set by earlier clamping vectors
    check("R9 flag after table", {127'b0, satFlag}, 128'h1);
    @(negedge clk);
    check("R7 resValid idle", {127'b0, resValid}, 128'h0);

    doOp(VECS[0], 1'b0);
    check("R9 flag holds on clean op", {127'b0, satFlag}, 128'h1);

    @(negedge clk); clearFlag = 1'b1;
    @(negedge clk); clearFlag = 1'b0;
    check("R10 clear alone", {127'b0, satFlag}, 128'h0);

    doOp(VECS[1], 1'b1);
    check("R10 clear beats set", {127'b0, satFlag}, 128'h0);
    check("R10 mask still reported", {112'b0, satMask}, 128'hFFFF);

    doOp(VECS[7], 1'b0);
    check("R6 upper lanes ignored for flag", {127'b0, satFlag}, 128'h0);

    doOp(VECS[3], 1'b0);
    check("R9 flag set by clamp", {127'b0, satFlag}, 128'h1);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule